// File: doc/BRIEF.md
# Color Palette Memory Byte-Pair Write Port

This block holds a 256-entry table of 16-bit color words. A host bus that is only 8 bits wide fills the table through two registers: an index register that picks the destination entry, and a data register that takes bytes. The port keeps a hidden phase bit. The first data byte after the phase is cleared is held back. The second byte supplies the upper half of the word. The two bytes are then stored together as one 16-bit word, and the index steps to the next entry. A host can therefore stream a whole palette with one index write followed by a run of byte pairs.

Each stored word carries three 5-bit color channels. Red sits in bits 4:0, green in bits 9:5 and blue in bits 14:10. Bit 15 carries no information and is always stored as zero. The renderer treats entry 0 of each palette as transparent, but this block does nothing special for it. The rendering side has its own read port. It presents an entry index and gets the stored word back one clock later.

Top module: `cpal_write_port`

## Requirements
- R1: A synchronous active-high `rst` clears the index register to 0x00, clears the phase bit and clears the held byte, so that the first byte pair written after reset lands in entry 0x00. Table contents are not cleared.
- R2: A data write (`bus_we`=1, `bus_sel`=1) while the phase bit is clear holds the byte as the low half and changes no table entry.
- R3: A data write while the phase bit is set stores {high byte, held low byte} into the entry selected by the index register.
- R4: After a pair is stored, the index increments by one and the phase bit clears. Consecutive pairs therefore fill consecutive entries.
- R5: The index wraps from 0xFF to 0x00 when it increments.
- R6: Bit 15 of every stored word is zero, whatever the host writes in bit 7 of the high byte.
- R7: An index write (`bus_we`=1, `bus_sel`=0) clears the phase bit. A low byte held before the index write is discarded, and the next data byte is taken as a new low half.
- R8: An index write loads `bus_wdata` (any value 0x00 to 0xFF) as the destination entry and stores nothing in the table.
- R9: `rd_color` shows the word stored at `rd_idx` one clock after `rd_idx` is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host write strobe, one byte per cycle |
| bus_sel | input | 1 | Register select: 0 = index register, 1 = data register |
| bus_wdata | input | 8 | Host write byte |
| rd_idx | input | 8 | Render-side entry index |
| rd_color | output | 16 | Stored color word at `rd_idx`, one cycle late |

## Verification
The hardest state to reach from the ports is a half-finished pair that gets interrupted. This happens when a low byte is already held and then an index write or a reset arrives before the high byte. The bench places a lone low byte, then sends the interrupting event, then writes a complete pair. It then reads back both the old and the new entries to show that the orphaned byte went nowhere. Index wrap is reached by loading 0xFF and writing two pairs in a row.

// File: rtl/cpal_pkg.sv
package cpal_pkg;
   typedef enum logic {
      SEL_INDEX = 1'b0,
      SEL_DATA  = 1'b1
   } cpal_sel_e;
endpackage

// File: rtl/cpal_index_reg.sv
module cpal_index_reg #(
   parameter int ADDR_W = 8,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] idx_o
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   if (ADDR_W > BYTE_W) begin : g_bad_width
      $error("cpal_index_reg: index wider than host byte");
   end

   logic [ADDR_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst)
         idx_q <= '0;
      else if (load)
         idx_q <= load_val[ADDR_W-1:0];
      else if (step)
         idx_q <= idx_q + ONE;   // natural wrap at the top entry
   end

   assign idx_o = idx_q;
endmodule

// File: rtl/cpal_pair_latch.sv
module cpal_pair_latch #(
   parameter int BYTE_W    = 8,
   parameter int WORD_W    = 16,
   parameter int KEEP_BITS = 15
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              data_we,
   input  logic [BYTE_W-1:0] data,
   output logic              phase_o,
   output logic              commit_o,
   output logic [WORD_W-1:0] word_o
);
   if (WORD_W != 2 * BYTE_W) begin : g_bad_word
      $error("cpal_pair_latch: word must be two host bytes");
   end
   if (KEEP_BITS < 1 || KEEP_BITS > WORD_W) begin : g_bad_keep
      $error("cpal_pair_latch: KEEP_BITS out of range");
   end

   logic              phase_q;
   logic [BYTE_W-1:0] held_q;
   logic [WORD_W-1:0] raw_word;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= 1'b0;
         held_q  <= '0;
      end else if (clr) begin
         phase_q <= 1'b0;
      end else if (data_we) begin
         if (!phase_q) held_q <= data;
         phase_q <= ~phase_q;
      end
   end

   assign raw_word = {data, held_q};
   assign commit_o = data_we & phase_q & ~clr;
   assign phase_o  = phase_q;

   if (KEEP_BITS == WORD_W) begin : g_no_mask
      assign word_o = raw_word;
   end else begin : g_mask
      assign word_o = {{(WORD_W-KEEP_BITS){1'b0}}, raw_word[KEEP_BITS-1:0]};
   end
endmodule

// File: rtl/cpal_color_mem.sv
module cpal_color_mem #(
   parameter int ADDR_W = 8,
   parameter int WORD_W = 16,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (RD_LAT != 0 && RD_LAT != 1) begin : g_bad_lat
      $error("cpal_color_mem: RD_LAT must be 0 or 1");
   end

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   if (RD_LAT == 1) begin : g_reg_read
      logic [WORD_W-1:0] rdata_q;
      always_ff @(posedge clk) rdata_q <= mem[raddr];
      assign rdata = rdata_q;
   end else begin : g_comb_read
      assign rdata = mem[raddr];
   end
endmodule

// File: rtl/cpal_write_port.sv
module cpal_write_port #(
   parameter int ADDR_W    = 8,
   parameter int BYTE_W    = 8,
   parameter int KEEP_BITS = 15,
   parameter int RD_LAT    = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                bus_we,
   input  logic                bus_sel,
   input  logic [BYTE_W-1:0]   bus_wdata,
   input  logic [ADDR_W-1:0]   rd_idx,
   output logic [2*BYTE_W-1:0] rd_color
);
   import cpal_pkg::*;

   localparam int WORD_W = 2 * BYTE_W;

   logic              idx_wr;
   logic              data_wr;
   logic              phase;
   logic              commit;
   logic [WORD_W-1:0] commit_word;
   logic [ADDR_W-1:0] idx;

   assign idx_wr  = bus_we & (cpal_sel_e'(bus_sel) == SEL_INDEX);
   assign data_wr = bus_we & (cpal_sel_e'(bus_sel) == SEL_DATA);

   cpal_index_reg #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_index (
      .clk      (clk),
      .rst      (rst),
      .load     (idx_wr),
      .load_val (bus_wdata),
      .step     (commit),
      .idx_o    (idx)
   );

   cpal_pair_latch #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .KEEP_BITS(KEEP_BITS)) u_pair (
      .clk      (clk),
      .rst      (rst),
      .clr      (idx_wr),
      .data_we  (data_wr),
      .data     (bus_wdata),
      .phase_o  (phase),
      .commit_o (commit),
      .word_o   (commit_word)
   );

   cpal_color_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RD_LAT(RD_LAT)) u_mem (
      .clk   (clk),
      .we    (commit),
      .waddr (idx),
      .wdata (commit_word),
      .raddr (rd_idx),
      .rdata (rd_color)
   );
endmodule

// File: rtl/cpal_port_chk.sv
module cpal_port_chk #(
   parameter int ADDR_W    = 8,
   parameter int WORD_W    = 16,
   parameter int KEEP_BITS = 15
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_we,
   input logic              bus_sel,
   input logic              phase,
   input logic              commit,
   input logic [WORD_W-1:0] commit_word,
   input logic [ADDR_W-1:0] idx
);
   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (idx == '0 && !phase));

   a_r2_low_holds: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_sel && !phase) |=> (phase && $stable(idx)));

   a_r2_low_no_store: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_sel && !phase) |-> !commit);

   a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
      commit |=> (idx == ADDR_W'($past(idx) + 1'b1)));

   a_r4_phase_back: assert property (@(posedge clk) disable iff (rst)
      commit |=> !phase);

   a_r6_top_zero: assert property (@(posedge clk) disable iff (rst)
      commit |-> ((commit_word >> KEEP_BITS) == '0));

   a_r7_index_clears: assert property (@(posedge clk) disable iff (rst)
      (bus_we && !bus_sel) |=> !phase);

   a_r8_index_no_store: assert property (@(posedge clk) disable iff (rst)
      (bus_we && !bus_sel) |-> !commit);
endmodule

bind cpal_write_port cpal_port_chk #(
   .ADDR_W(ADDR_W), .WORD_W(WORD_W), .KEEP_BITS(KEEP_BITS)
) u_port_chk (
   .clk         (clk),
   .rst         (rst),
   .bus_we      (bus_we),
   .bus_sel     (bus_sel),
   .phase       (phase),
   .commit      (commit),
   .commit_word (commit_word),
   .idx         (idx)
);

// File: tb/test_cpal_write_port.sv
module test_cpal_write_port;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_we = 1'b0;
   logic        bus_sel = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  rd_idx = '0;
   logic [15:0] rd_color;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [15:0] exp;
      logic [7:0]  idx;
      string       tag;
   } item_t;

   item_t       sb[$];
   logic        rd_req = 1'b0;
   logic        rd_pend = 1'b0;

   // requirement-level model
   logic [15:0] m_mem [256];
   logic [7:0]  m_idx;
   logic        m_phase;
   logic [7:0]  m_low;

   always #4 clk = ~clk;

   cpal_write_port i_cpal_write_port (
      .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .rd_idx(rd_idx), .rd_color(rd_color)
   );

   always_ff @(posedge clk) rd_pend <= rd_req;

   // monitor: compare one cycle after each read request
   always @(negedge clk) begin
      if (rd_pend) begin
         item_t it;
         it = sb.pop_front();
         total++;
         if (rd_color !== it.exp) begin
            bad++;
            $display("FAIL %s entry %02h: actual=%04h expected=%04h",
                     it.tag, it.idx, rd_color, it.exp);
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      m_idx = '0; m_phase = 1'b0; m_low = '0;
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
      if (!sel) begin
         m_idx = d; m_phase = 1'b0;
      end else if (!m_phase) begin
         m_low = d; m_phase = 1'b1;
      end else begin
         m_mem[m_idx] = {1'b0, d[6:0], m_low};
         m_idx = m_idx + 8'd1;
         m_phase = 1'b0;
      end
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic pair(input logic [7:0] lo, input logic [7:0] hi);
      wr(1'b1, lo);
      wr(1'b1, hi);
   endtask

   task automatic rd(input logic [7:0] i, input string tag);
      item_t it;
      @(negedge clk);
      rd_idx = i; rd_req = 1'b1;
      it.exp = m_mem[i]; it.idx = i; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      do_reset();
      // R1: first pair after reset goes to entry 0
      pair(8'hA1, 8'h12);
      rd(8'h00, "R1");
      // R4: next pair lands in next entry; R9 read latency
      pair(8'h34, 8'h56);
      rd(8'h01, "R4");
      rd(8'h00, "R9");
      // R8, R3: index load then pair
      wr(1'b0, 8'h10);
      rd(8'h02, "R8");
      m_mem[8'h10] = 16'hxxxx;
      pair(8'hC3, 8'h2D);
      rd(8'h10, "R3");
      // R2: lone low byte stores nothing
      wr(1'b0, 8'h10);
      wr(1'b1, 8'h77);
      rd(8'h10, "R2");
      wr(1'b1, 8'h05);
      rd(8'h10, "R3");
      // R7: index write drops held low byte
      wr(1'b0, 8'h20);
      pair(8'h11, 8'h11);
      wr(1'b0, 8'h20);
      wr(1'b1, 8'hAA);
      wr(1'b0, 8'h21);
      pair(8'hBB, 8'h3C);
      rd(8'h20, "R7");
      rd(8'h21, "R7");
      pair(8'h01, 8'h02);
      rd(8'h22, "R4");
      // R6: top bit forced to zero
      wr(1'b0, 8'h30);
      pair(8'hFF, 8'hFF);
      rd(8'h30, "R6");
      pair(8'h00, 8'h80);
      rd(8'h31, "R6");
      // R5: wrap from FF to 00
      wr(1'b0, 8'hFF);
      pair(8'h5A, 8'h4B);
      pair(8'h6C, 8'h1D);
      rd(8'hFF, "R5");
      rd(8'h00, "R5");
      // R4: burst of pairs
      wr(1'b0, 8'h40);
      for (int k = 0; k < 8; k++) pair(8'(k * 17 + 3), 8'(k * 9 + 1));
      for (int k = 0; k < 8; k++) rd(8'(8'h40 + k), "R4");
      // R1: reset in mid pair discards held byte, index returns to 0
      wr(1'b0, 8'h50);
      wr(1'b1, 8'h99);
      do_reset();
      pair(8'h01, 8'h02);
      rd(8'h00, "R1");
      rd(8'h01, "R1");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule